// File: doc/BRIEF.md
# Single-Cycle Printer Controller Core

This block is a small controller core with an 8-bit datapath. On every clock it takes one 16-bit instruction from an external program ROM and completes it in that same clock. The ROM is addressed by a 9-bit program counter. The working state is an A register, a B register, a carry flag and 32 bytes of register RAM. The register RAM is split into two banks of sixteen. A bank bit in every instruction picks the bank for all register operands of that instruction.

The core reaches the rest of a printer controller through simple parallel buses:
- a numbered output port bus with a one-clock strobe;
- a numbered input port bus;
- an auxiliary input bus that feeds the B operand;
- a read port into an external translation table.

Most instructions move their result through A and then leave B and carry cleared. The only control transfer is an unconditional jump. A run-enable input freezes the whole core while it is low. The A, B and carry state is brought out on ports so that the surrounding logic can observe it.

Top module: `prc_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter (`rom_addr`), A, B and carry to zero.
- R2: While `run_en` is high, the program counter advances by one on every clock and wraps from 511 to 0. While `run_en` is low, the PC, A, B, carry and register RAM hold their values, and `out_strobe` stays low.
- R3: Instruction fields are fixed:
  - bits 2:0 are the opcode, and bit 3 is the bank bit, which adds 16 to every register index;
  - the source register index is in bits 11:8;
  - the destination register index is in bits 7:4;
  - the 8-bit immediate is in bits 15:8.
- R4: Opcode 0 (emit) drives the source register onto `out_data` with `out_port_sel` = bits 6:4 and `out_strobe` high in that cycle. It loads A with that value and clears B and carry.
- R5: Opcode 1 (jump) loads the PC with {bit 3, bits 15:8}. It loads A with bits 15:8 and clears B and carry.
- R6: Opcode 2 (fetch) sets `in_port_sel` = {0, bits 10:8}. It loads A from `in_port_data` and B from `aux_data`. Carry becomes the carry-out of A + B + old carry. No register is written.
- R7: Opcode 3 (test) loads A with the immediate and B with the destination register. Carry is set exactly when (A AND B) is nonzero.
- R8: Opcode 4 with bits 15:14 = 01 (table) sets the 9-bit `xlat_addr` to B + carry. It loads A with `xlat_data`, writes that value to the destination register, and clears B and carry.
- R9: Opcode 4 selects its action with bits 15:14:
  - 11 copies the source register into the destination register;
  - 10 copies input port bits 11:8 (4-bit port number) into the destination register;
  - in both cases the value is also loaded into A, and B and carry are cleared;
  - 00 changes nothing but the PC.
- R10: Opcode 5 (load) writes the immediate to A and to the destination register, and clears B and carry.
- R11: Opcode 6 (add) loads A from the source register and B from the destination register. It writes the low 8 bits of A + B + carry-in to the destination register and sets carry to the carry-out.
- R12: Opcode 7 behaves like opcode 6, except that A is taken from the immediate.
- R13: `out_strobe` and the register write each last one clock, in the cycle of the instruction that causes them, and the two are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Execute enable; low freezes the core |
| rom_addr | output | 9 | Program counter, the program ROM address |
| rom_data | input | 16 | Instruction word at `rom_addr`, same cycle |
| out_port_sel | output | 3 | Output port number |
| out_data | output | 8 | Output port data |
| out_strobe | output | 1 | Output port write strobe |
| in_port_sel | output | 4 | Input port number |
| in_port_data | input | 8 | Data from the selected input port |
| aux_data | input | 8 | Auxiliary B operand bus |
| xlat_addr | output | 9 | Translation table address (B + carry) |
| xlat_data | input | 8 | Translation table data |
| acc_a | output | 8 | A register |
| acc_b | output | 8 | B register |
| carry_flag | output | 1 | Carry flag |

## Verification
The bench builds the core with its default parameters: a 9-bit program counter, 8-bit data and 32 register RAM entries. This puts the whole 512-word program space within reach, including the wrap from 511 back to 0 after a jump into bank-bit-high space.

The full 9-bit table address is also reachable. With B = 0xFF and carry set, the table address becomes 0x100.

Both register banks are exercised through the same low index, so a bank bit that is ignored shows up as a wrong emitted value.

// File: rtl/prc_pkg.sv
package prc_pkg;
    localparam int DATA_W   = 8;
    localparam int INSTR_W  = 16;
    localparam int PROG_AW  = 9;
    localparam int REG_CNT  = 32;
    localparam int REG_AW   = $clog2(REG_CNT);
    localparam int OPORT_W  = 3;
    localparam int IPORT_W  = 4;

    typedef enum logic [2:0] {
        OP_EMIT = 3'd0, OP_JUMP = 3'd1, OP_FETCH = 3'd2, OP_TEST = 3'd3,
        OP_EXT  = 3'd4, OP_LOAD = 3'd5, OP_ADDR  = 3'd6, OP_ADDI = 3'd7
    } opc_e;

    typedef enum logic [1:0] {
        SUB_NOP = 2'b00, SUB_TABLE = 2'b01, SUB_PORT = 2'b10, SUB_MOVE = 2'b11
    } sub_e;

    typedef struct packed {
        opc_e                op;
        sub_e                sub;
        logic [REG_AW-1:0]   src;
        logic [REG_AW-1:0]   dst;
        logic [DATA_W-1:0]   imm;
        logic [OPORT_W-1:0]  oport;
        logic [IPORT_W-1:0]  iport;
        logic [PROG_AW-1:0]  target;
    } dec_t;
endpackage

// File: rtl/prc_decode.sv
module prc_decode
    import prc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic bank;
    assign bank = instr[3];

    always_comb begin
        dec.op     = opc_e'(instr[2:0]);
        dec.sub    = sub_e'(instr[15:14]);
        dec.src    = {bank, instr[11:8]};
        dec.dst    = {bank, instr[7:4]};
        dec.imm    = instr[15:8];
        dec.oport  = instr[6:4];
        dec.iport  = (dec.op == OP_FETCH) ? {1'b0, instr[10:8]} : instr[11:8];
        dec.target = {bank, instr[15:8]};
    end
endmodule

// File: rtl/prc_regfile.sv
module prc_regfile #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_s,
    input  logic [AW-1:0] raddr_d,
    output logic [DW-1:0] rdata_s,
    output logic [DW-1:0] rdata_d
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata_s = mem[raddr_s];
    assign rdata_d = mem[raddr_d];
endmodule

// File: rtl/prc_adder.sv
module prc_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout
);
    logic [DW:0] full;
    assign full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    assign sum  = full[DW-1:0];
    assign cout = full[DW];
endmodule

// File: rtl/prc_core.sv
module prc_core
    import prc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    output logic [PROG_AW-1:0]  rom_addr,
    input  logic [INSTR_W-1:0]  rom_data,
    output logic [OPORT_W-1:0]  out_port_sel,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_strobe,
    output logic [IPORT_W-1:0]  in_port_sel,
    input  logic [DATA_W-1:0]   in_port_data,
    input  logic [DATA_W-1:0]   aux_data,
    output logic [DATA_W:0]     xlat_addr,
    input  logic [DATA_W-1:0]   xlat_data,
    output logic [DATA_W-1:0]   acc_a,
    output logic [DATA_W-1:0]   acc_b,
    output logic                carry_flag
);
    dec_t               dec;
    logic [PROG_AW-1:0] pc, nxt_pc;
    logic [DATA_W-1:0]  a_q, b_q, nxt_a, nxt_b;
    logic               c_q, nxt_c;
    logic [DATA_W-1:0]  rd_s, rd_d, rf_wd, add_a, add_b, add_sum;
    logic               rf_we, add_co, strobe;

    prc_decode u_dec (.instr(rom_data), .dec(dec));

    prc_regfile #(.DW(DATA_W), .DEPTH(REG_CNT)) u_rf (
        .clk(clk), .we(rf_we), .waddr(dec.dst), .wdata(rf_wd),
        .raddr_s(dec.src), .raddr_d(dec.dst), .rdata_s(rd_s), .rdata_d(rd_d)
    );

    assign add_a = (dec.op == OP_FETCH) ? in_port_data :
                   (dec.op == OP_ADDI)  ? dec.imm : rd_s;
    assign add_b = (dec.op == OP_FETCH) ? aux_data : rd_d;

    prc_adder #(.DW(DATA_W)) u_add (
        .a(add_a), .b(add_b), .cin(c_q), .sum(add_sum), .cout(add_co)
    );

    always_comb begin
        nxt_pc = pc + 1'b1;
        nxt_a  = a_q;
        nxt_b  = b_q;
        nxt_c  = c_q;
        rf_we  = 1'b0;
        rf_wd  = rd_s;
        strobe = 1'b0;
        unique case (dec.op)
            OP_EMIT: begin
                nxt_a = rd_s; nxt_b = '0; nxt_c = 1'b0; strobe = 1'b1;
            end
            OP_JUMP: begin
                nxt_pc = dec.target; nxt_a = dec.imm; nxt_b = '0; nxt_c = 1'b0;
            end
            OP_FETCH: begin
                nxt_a = in_port_data; nxt_b = aux_data; nxt_c = add_co;
            end
            OP_TEST: begin
                nxt_a = dec.imm; nxt_b = rd_d; nxt_c = |(dec.imm & rd_d);
            end
            OP_EXT: begin
                unique case (dec.sub)
                    SUB_TABLE: begin
                        nxt_a = xlat_data; rf_wd = xlat_data; rf_we = 1'b1;
                        nxt_b = '0; nxt_c = 1'b0;
                    end
                    SUB_PORT: begin
                        nxt_a = in_port_data; rf_wd = in_port_data; rf_we = 1'b1;
                        nxt_b = '0; nxt_c = 1'b0;
                    end
                    SUB_MOVE: begin
                        nxt_a = rd_s; rf_wd = rd_s; rf_we = 1'b1;
                        nxt_b = '0; nxt_c = 1'b0;
                    end
                    SUB_NOP: ;
                endcase
            end
            OP_LOAD: begin
                nxt_a = dec.imm; rf_wd = dec.imm; rf_we = 1'b1;
                nxt_b = '0; nxt_c = 1'b0;
            end
            OP_ADDR, OP_ADDI: begin
                nxt_a = add_a; nxt_b = rd_d; nxt_c = add_co;
                rf_wd = add_sum; rf_we = 1'b1;
            end
        endcase
        if (!run_en) begin
            nxt_pc = pc; nxt_a = a_q; nxt_b = b_q; nxt_c = c_q;
            rf_we  = 1'b0; strobe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0; a_q <= '0; b_q <= '0; c_q <= 1'b0;
        end else begin
            pc <= nxt_pc; a_q <= nxt_a; b_q <= nxt_b; c_q <= nxt_c;
        end
    end

    assign rom_addr     = pc;
    assign out_port_sel = dec.oport;
    assign out_data     = rd_s;
    assign out_strobe   = strobe;
    assign in_port_sel  = dec.iport;
    assign xlat_addr    = {1'b0, b_q} + {{DATA_W{1'b0}}, c_q};
    assign acc_a        = a_q;
    assign acc_b        = b_q;
    assign carry_flag   = c_q;

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (!out_strobe && !rf_we));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (rom_addr == $past(rom_addr) && acc_a == $past(acc_a)
                     && carry_flag == $past(carry_flag)));
    p_step_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (run_en && dec.op != OP_JUMP) |=> rom_addr == $past(rom_addr) + 1'b1);
    p_jump_dest_r5: assert property (@(posedge clk) disable iff (rst)
        (run_en && dec.op == OP_JUMP) |=>
            (rom_addr == $past(dec.target) && acc_b == '0 && !carry_flag));
    p_emit_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (run_en && dec.op == OP_EMIT) |=> (acc_b == '0 && !carry_flag
                                           && acc_a == $past(out_data)));
    p_one_effect_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_strobe, rf_we}));
    p_test_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (run_en && dec.op == OP_TEST) |=> carry_flag == |(acc_a & acc_b));
endmodule

// File: tb/prc_core_tb_top.sv
module prc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic [8:0]  rom_addr;
    logic [15:0] rom_data;
    logic [2:0]  out_port_sel;
    logic [7:0]  out_data;
    logic        out_strobe;
    logic [3:0]  in_port_sel;
    logic [7:0]  in_port_data;
    logic [7:0]  aux_data = 8'hC9;
    logic [8:0]  xlat_addr;
    logic [7:0]  xlat_data;
    logic [7:0]  acc_a, acc_b;
    logic        carry_flag;

    logic [15:0] rom [512];
    int checks = 0;
    int errors = 0;
    localparam logic [15:0] NOP = 16'h0004;

    always #5 clk = ~clk;

    assign rom_data     = rom[rom_addr];
    assign in_port_data = {in_port_sel, 4'h7};
    assign xlat_data    = xlat_addr[7:0] ^ (xlat_addr[8] ? 8'h96 : 8'h3C);

    prc_core dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .rom_addr(rom_addr), .rom_data(rom_data),
        .out_port_sel(out_port_sel), .out_data(out_data), .out_strobe(out_strobe),
        .in_port_sel(in_port_sel), .in_port_data(in_port_data), .aux_data(aux_data),
        .xlat_addr(xlat_addr), .xlat_data(xlat_data), .acc_a(acc_a), .acc_b(acc_b),
        .carry_flag(carry_flag)
    );

    function automatic logic [15:0] i_emit(logic bk, logic [3:0] s, logic [2:0] p);
        return {4'h0, s, 1'b0, p, bk, 3'd0};
    endfunction
    function automatic logic [15:0] i_jump(logic [8:0] t);
        return {t[7:0], 4'h0, t[8], 3'd1};
    endfunction
    function automatic logic [15:0] i_fetch(logic [2:0] p);
        return {5'h0, p, 4'h0, 1'b0, 3'd2};
    endfunction
    function automatic logic [15:0] i_imm(logic [2:0] op, logic [7:0] imm, logic bk, logic [3:0] d);
        return {imm, d, bk, op};
    endfunction
    function automatic logic [15:0] i_ext(logic [1:0] sub, logic [3:0] s, logic [3:0] d, logic bk);
        return {sub, 2'b00, s, d, bk, 3'd4};
    endfunction
    function automatic logic [15:0] i_addr(logic bk, logic [3:0] s, logic [3:0] d);
        return {4'h0, s, d, bk, 3'd6};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 512; i++) rom[i] = NOP;
    endtask

    task automatic start();
        run_en = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        clear_rom();
        rom[0] = i_imm(3'd3, 8'hFF, 1'b0, 4'd0);
        rom[1] = i_jump(9'h155);
        start();
        step(2);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        chk("R1 pc", {7'b0, rom_addr}, 16'h0);
        chk("R1 a", {8'b0, acc_a}, 16'h0);
        chk("R1 b", {8'b0, acc_b}, 16'h0);
        chk("R1 carry", {15'b0, carry_flag}, 16'h0);
    endtask

    task automatic t_emit_banks();
        clear_rom();
        rom[0] = i_imm(3'd5, 8'h3C, 1'b0, 4'd5);
        rom[1] = i_imm(3'd5, 8'hC3, 1'b1, 4'd5);
        rom[2] = i_emit(1'b0, 4'd5, 3'd6);
        rom[3] = i_emit(1'b1, 4'd5, 3'd2);
        start();
        chk("R13 no strobe on load", {15'b0, out_strobe}, 16'h0);
        step(2);
        chk("R4 strobe", {15'b0, out_strobe}, 16'h1);
        chk("R4 port", {13'b0, out_port_sel}, 16'h6);
        chk("R3 R10 bank0 data", {8'b0, out_data}, 16'h3C);
        step(1);
        chk("R3 R10 bank1 data", {8'b0, out_data}, 16'hC3);
        chk("R4 port2", {13'b0, out_port_sel}, 16'h2);
        step(1);
        chk("R13 strobe one cycle", {15'b0, out_strobe}, 16'h0);
        chk("R4 a", {8'b0, acc_a}, 16'hC3);
        chk("R4 b/c clear", {7'b0, acc_b, carry_flag}, 16'h0);
    endtask

    task automatic t_jump_hold();
        clear_rom();
        rom[0]     = i_jump(9'h1F0);
        rom[9'h1F0] = i_emit(1'b0, 4'd0, 3'd7);
        start();
        step(1);
        chk("R5 target", {7'b0, rom_addr}, 16'h1F0);
        chk("R5 a", {8'b0, acc_a}, 16'hF0);
        run_en = 1'b0;
        #1;
        chk("R2 strobe gated", {15'b0, out_strobe}, 16'h0);
        step(3);
        chk("R2 pc held", {7'b0, rom_addr}, 16'h1F0);
        chk("R2 a held", {8'b0, acc_a}, 16'hF0);
        run_en = 1'b1;
        #1;
        chk("R2 strobe resumes", {15'b0, out_strobe}, 16'h1);
        chk("R4 port7", {13'b0, out_port_sel}, 16'h7);
        step(15);
        chk("R2 pc 1FF", {7'b0, rom_addr}, 16'h1FF);
        step(1);
        chk("R2 wrap", {7'b0, rom_addr}, 16'h0);
    endtask

    task automatic t_add();
        clear_rom();
        rom[0] = i_imm(3'd5, 8'hF0, 1'b0, 4'd2);
        rom[1] = i_imm(3'd5, 8'h20, 1'b0, 4'd3);
        rom[2] = i_imm(3'd5, 8'h0A, 1'b0, 4'd4);
        rom[3] = i_addr(1'b0, 4'd2, 4'd3);
        rom[4] = i_imm(3'd7, 8'hF6, 1'b0, 4'd4);
        rom[5] = i_emit(1'b0, 4'd3, 3'd1);
        rom[6] = i_emit(1'b0, 4'd4, 3'd1);
        start();
        step(4);
        chk("R11 a", {8'b0, acc_a}, 16'hF0);
        chk("R11 b", {8'b0, acc_b}, 16'h20);
        chk("R11 carry out", {15'b0, carry_flag}, 16'h1);
        step(1);
        chk("R12 a", {8'b0, acc_a}, 16'hF6);
        chk("R12 b", {8'b0, acc_b}, 16'h0A);
        chk("R12 carry in+out", {15'b0, carry_flag}, 16'h1);
        chk("R11 sum", {8'b0, out_data}, 16'h10);
        step(1);
        chk("R12 sum", {8'b0, out_data}, 16'h01);
    endtask

    task automatic t_fetch();
        clear_rom();
        rom[0] = i_imm(3'd5, 8'hFF, 1'b0, 4'd0);
        rom[1] = i_imm(3'd7, 8'hFF, 1'b0, 4'd0);
        rom[2] = i_fetch(3'd3);
        rom[3] = i_imm(3'd5, 8'h00, 1'b0, 4'd1);
        rom[4] = i_fetch(3'd1);
        start();
        step(2);
        chk("R6 port sel", {12'b0, in_port_sel}, 16'h3);
        step(1);
        chk("R6 a", {8'b0, acc_a}, 16'h37);
        chk("R6 b", {8'b0, acc_b}, 16'hC9);
        chk("R6 carry set", {15'b0, carry_flag}, 16'h1);
        step(2);
        chk("R6 a p1", {8'b0, acc_a}, 16'h17);
        chk("R6 carry clear", {15'b0, carry_flag}, 16'h0);
    endtask

    task automatic t_test();
        clear_rom();
        rom[0] = i_imm(3'd5, 8'h81, 1'b1, 4'd6);
        rom[1] = i_imm(3'd3, 8'h01, 1'b1, 4'd6);
        rom[2] = i_imm(3'd3, 8'h7E, 1'b1, 4'd6);
        start();
        step(2);
        chk("R7 b", {8'b0, acc_b}, 16'h81);
        chk("R7 hit", {15'b0, carry_flag}, 16'h1);
        step(1);
        chk("R7 a", {8'b0, acc_a}, 16'h7E);
        chk("R7 miss", {15'b0, carry_flag}, 16'h0);
    endtask

    task automatic t_ext();
        clear_rom();
        rom[0]  = i_imm(3'd5, 8'hFF, 1'b0, 4'd7);
        rom[1]  = i_imm(3'd3, 8'h01, 1'b0, 4'd7);
        rom[2]  = i_ext(2'b01, 4'd0, 4'd8, 1'b0);
        rom[3]  = i_ext(2'b11, 4'd8, 4'd9, 1'b0);
        rom[4]  = i_ext(2'b10, 4'd12, 4'd10, 1'b0);
        rom[5]  = i_imm(3'd3, 8'hFF, 1'b0, 4'd7);
        rom[6]  = NOP;
        rom[7]  = i_emit(1'b0, 4'd9, 3'd0);
        rom[8]  = i_emit(1'b0, 4'd10, 3'd0);
        rom[9]  = i_emit(1'b0, 4'd8, 3'd0);
        start();
        step(2);
        chk("R8 table addr", {7'b0, xlat_addr}, 16'h100);
        step(1);
        chk("R8 a", {8'b0, acc_a}, 16'h96);
        chk("R8 b/c clear", {7'b0, acc_b, carry_flag}, 16'h0);
        step(2);
        chk("R9 port a", {8'b0, acc_a}, 16'hC7);
        step(1);
        step(1);
        chk("R9 nop a", {8'b0, acc_a}, 16'hFF);
        chk("R9 nop b", {8'b0, acc_b}, 16'hFF);
        chk("R9 nop carry", {15'b0, carry_flag}, 16'h1);
        chk("R9 nop pc", {7'b0, rom_addr}, 16'h7);
        chk("R9 move", {8'b0, out_data}, 16'h96);
        step(1);
        chk("R9 port copy", {8'b0, out_data}, 16'hC7);
        step(1);
        chk("R8 reg write", {8'b0, out_data}, 16'h96);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_rom();
        step(2);
        t_reset();
        t_emit_banks();
        t_jump_hold();
        t_add();
        t_fetch();
        t_test();
        t_ext();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule